// File: doc/BRIEF.md
# Adapter Option-Select and Memory Window Decoder

This block is the host-side configuration front end of a plug-in network adapter on a 20-bit host address bus. It has eight byte-wide I/O locations. Two of them return a fixed identification pair, so a probe can find the card. One holds the card-enable and boot-EPROM-disable bits. One places a 16 KB memory window anywhere from 0xA0000 to 0xFC000. One is a plain read/write byte for the interrupt line choice. The remaining three are unused.

Host memory cycles are decoded combinationally against the programmed window. The low part of the window is shared packet RAM. Next comes a 32-byte address PROM, of which only even bytes carry data. A 16-byte reserved gap follows. The top of the map holds the three controller-access registers: a 16-bit data register, a status/control byte and a command byte. The block drives a one-hot set of selects plus the sub-field indices that the downstream storage needs.

Top module: `optsel_window_top`

## Requirements
- R1: I/O offset 0 reads 0xFD and offset 1 reads 0x6A at all times, and writes to them change nothing.
- R2: At offset 2, bit 0 is the card enable (card_en_o) and bit 1 is the boot-EPROM disable (eprom_en_o = NOT bit 1). Reads return {6'b0, bit1, bit0}.
- R3: Offset 3 stores write bits 5:0 as host address bits 19:14 of the window base and reads back {2'b00, base}.
- R4: After reset, offsets 2, 3 and 4 read 0x00, and no memory select is active.
- R5: No memory select is active while the card enable is 0.
- R6: No memory select is active while the base field is below 0x28, i.e. the window would start below 0xA0000.
- R7: A hit at window offset 0x0000..0x3FBF asserts ram_sel_o.
- R8: A hit at offset 0x3FC0..0x3FDF asserts prom_sel_o, with prom_idx_o = offset bits 4:1 and prom_odd_o = offset bit 0. Both indices are 0 when prom_sel_o is low.
- R9: Offsets 0x3FE0..0x3FEF and 0x3FF4..0x3FFF assert no select.
- R10: Offsets 0x3FF0/0x3FF1 assert ctl_data_sel_o, with ctl_byte_hi_o = offset bit 0 (0 when not selected). 0x3FF2 asserts ctl_stat_sel_o and 0x3FF3 asserts ctl_cmd_sel_o.
- R11: Offset 4 is a read/write byte. Offsets 5..7 read 0xFF, and writes to them change no register.
- R12: At most one select is active. All selects are low when mem_valid_i is low, and they follow the address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_sel_i | input | 1 | I/O cycle to the option bank |
| io_wr_i | input | 1 | 1 = write, 0 = read |
| io_off_i | input | 3 | Option register offset |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data for io_off_i |
| mem_valid_i | input | 1 | Host memory cycle valid |
| mem_addr_i | input | 20 | Host memory address |
| card_en_o | output | 1 | Card enabled |
| eprom_en_o | output | 1 | Boot EPROM enabled |
| ram_sel_o | output | 1 | Shared RAM select |
| prom_sel_o | output | 1 | Address PROM select |
| prom_idx_o | output | 4 | PROM byte index |
| prom_odd_o | output | 1 | Odd PROM address (data undefined) |
| ctl_data_sel_o | output | 1 | Controller data register select |
| ctl_byte_hi_o | output | 1 | High byte of the data register |
| ctl_stat_sel_o | output | 1 | Status/control byte select |
| ctl_cmd_sel_o | output | 1 | Command byte select |

## Verification
The hardest cases to reach are at the edges of the window map. These are the last RAM byte 0x3FBF, the first PROM byte and the seams around the reserved gap and the unmapped top bytes. They also include bases at 0x27 and 0x28 and addresses that fall just outside the programmed window. Random addresses almost never land on those bytes. The stimulus therefore programs the base and enable through the I/O port and walks every one of these offsets directly. A seeded random sweep then mixes base values, enable states and addresses, and each one is checked against a bench decode function.

// File: rtl/optsel_pkg.sv
package optsel_pkg;
  localparam int WIN_W = 14;
  localparam logic [WIN_W-1:0] PROM_LO = 14'h3FC0;
  localparam logic [WIN_W-1:0] GAP_LO  = 14'h3FE0;
  localparam logic [WIN_W-1:0] CTL_LO  = 14'h3FF0;
  localparam int PROM_BLK_W = 5;  // 32-byte PROM block
  localparam int CTL_BLK_W  = 2;  // 4 controller bytes

  typedef enum logic [2:0] {
    OFF_ID_LO = 3'd0,
    OFF_ID_HI = 3'd1,
    OFF_CTRL  = 3'd2,
    OFF_BASE  = 3'd3,
    OFF_IRQ   = 3'd4
  } opt_off_e;

  typedef struct packed {
    logic ram;
    logic prom;
    logic ctl_data;
    logic ctl_stat;
    logic ctl_cmd;
  } win_sel_t;
endpackage

// File: rtl/optsel_regs.sv
module optsel_regs
  import optsel_pkg::*;
#(
  parameter int          OFF_W  = 3,
  parameter int          BASE_W = 6,
  parameter logic [7:0]  ID_LO  = 8'hFD,
  parameter logic [7:0]  ID_HI  = 8'h6A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_sel_i,
  input  logic              io_wr_i,
  input  logic [OFF_W-1:0]  io_off_i,
  input  logic [7:0]        io_wdata_i,
  output logic [7:0]        io_rdata_o,
  output logic              card_en_o,
  output logic              eprom_off_o,
  output logic [BASE_W-1:0] base_o
);
  logic              en_q, eoff_q;
  logic [BASE_W-1:0] base_q;
  logic [7:0]        irq_q;
  logic              wr;

  assign wr = io_sel_i & io_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      eoff_q <= 1'b0;
      base_q <= '0;
      irq_q  <= '0;
    end else if (wr) begin
      case (io_off_i)
        OFF_CTRL: begin
          en_q   <= io_wdata_i[0];
          eoff_q <= io_wdata_i[1];
        end
        OFF_BASE: base_q <= io_wdata_i[BASE_W-1:0];
        OFF_IRQ:  irq_q  <= io_wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (io_off_i)
      OFF_ID_LO: io_rdata_o = ID_LO;
      OFF_ID_HI: io_rdata_o = ID_HI;
      OFF_CTRL:  io_rdata_o = {6'b0, eoff_q, en_q};
      OFF_BASE:  io_rdata_o = {{(8-BASE_W){1'b0}}, base_q};
      OFF_IRQ:   io_rdata_o = irq_q;
      default:   io_rdata_o = 8'hFF;
    endcase
  end

  assign card_en_o   = en_q;
  assign eprom_off_o = eoff_q;
  assign base_o      = base_q;

  // R2
  en_follows_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && io_off_i == OFF_CTRL) |=> (card_en_o == $past(io_wdata_i[0])));

  // R11
  unused_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && io_off_i > OFF_IRQ) |=> ($stable(base_o) && $stable(card_en_o) && $stable(eprom_off_o)));

  // R1
  id_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_off_i == OFF_ID_LO) |-> (io_rdata_o == ID_LO));
endmodule

// File: rtl/optsel_decode.sv
module optsel_decode
  import optsel_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BASE_W = ADDR_W - WIN_W,
  parameter logic [BASE_W-1:0] BASE_MIN = 6'h28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mem_valid_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic              card_en_i,
  input  logic [BASE_W-1:0] base_i,
  output win_sel_t          sel_o,
  output logic [3:0]        prom_idx_o,
  output logic              prom_odd_o,
  output logic              ctl_byte_hi_o
);
  logic [WIN_W-1:0] off;
  logic             hit, base_ok;

  assign off     = mem_addr_i[WIN_W-1:0];
  assign base_ok = base_i >= BASE_MIN;
  assign hit     = mem_valid_i & card_en_i & base_ok & (mem_addr_i[ADDR_W-1:WIN_W] == base_i);

  always_comb begin
    sel_o = '0;
    if (hit) begin
      if (off < PROM_LO)
        sel_o.ram = 1'b1;
      else if (off[WIN_W-1:PROM_BLK_W] == PROM_LO[WIN_W-1:PROM_BLK_W])
        sel_o.prom = 1'b1;
      else if (off[WIN_W-1:CTL_BLK_W] == CTL_LO[WIN_W-1:CTL_BLK_W]) begin
        case (off[CTL_BLK_W-1:0])
          2'd2:    sel_o.ctl_stat = 1'b1;
          2'd3:    sel_o.ctl_cmd  = 1'b1;
          default: sel_o.ctl_data = 1'b1;
        endcase
      end
    end
  end

  assign prom_idx_o    = sel_o.prom ? off[4:1] : 4'd0;
  assign prom_odd_o    = sel_o.prom & off[0];
  assign ctl_byte_hi_o = sel_o.ctl_data & off[0];

  // R12
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));

  // R5
  sel_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o != '0) |-> card_en_i);

  // R6
  sel_needs_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o != '0) |-> (base_i >= BASE_MIN));

  // R9
  gap_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off >= GAP_LO && off < CTL_LO) |-> (sel_o == '0));
endmodule

// File: rtl/optsel_window_top.sv
module optsel_window_top
  import optsel_pkg::*;
#(
  parameter int         OFF_W    = 3,
  parameter int         ADDR_W   = 20,
  parameter logic [7:0] ID_LO    = 8'hFD,
  parameter logic [7:0] ID_HI    = 8'h6A,
  parameter int         MIN_BASE = 'hA0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_sel_i,
  input  logic              io_wr_i,
  input  logic [OFF_W-1:0]  io_off_i,
  input  logic [7:0]        io_wdata_i,
  output logic [7:0]        io_rdata_o,
  input  logic              mem_valid_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  output logic              card_en_o,
  output logic              eprom_en_o,
  output logic              ram_sel_o,
  output logic              prom_sel_o,
  output logic [3:0]        prom_idx_o,
  output logic              prom_odd_o,
  output logic              ctl_data_sel_o,
  output logic              ctl_byte_hi_o,
  output logic              ctl_stat_sel_o,
  output logic              ctl_cmd_sel_o
);
  localparam int BASE_W = ADDR_W - WIN_W;
  localparam logic [BASE_W-1:0] BASE_MIN = BASE_W'(MIN_BASE >> WIN_W);

  logic              eprom_off;
  logic [BASE_W-1:0] base;
  win_sel_t          sel;

  optsel_regs #(
    .OFF_W(OFF_W), .BASE_W(BASE_W), .ID_LO(ID_LO), .ID_HI(ID_HI)
  ) i_regs (
    .clk_i, .rst_ni, .io_sel_i, .io_wr_i, .io_off_i, .io_wdata_i, .io_rdata_o,
    .card_en_o, .eprom_off_o(eprom_off), .base_o(base)
  );

  optsel_decode #(
    .ADDR_W(ADDR_W), .BASE_W(BASE_W), .BASE_MIN(BASE_MIN)
  ) i_decode (
    .clk_i, .rst_ni, .mem_valid_i, .mem_addr_i,
    .card_en_i(card_en_o), .base_i(base),
    .sel_o(sel), .prom_idx_o, .prom_odd_o, .ctl_byte_hi_o
  );

  assign eprom_en_o     = ~eprom_off;
  assign ram_sel_o      = sel.ram;
  assign prom_sel_o     = sel.prom;
  assign ctl_data_sel_o = sel.ctl_data;
  assign ctl_stat_sel_o = sel.ctl_stat;
  assign ctl_cmd_sel_o  = sel.ctl_cmd;
endmodule

// File: tb/test_optsel_window_top.sv
module test_optsel_window_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       io_sel = 1'b0, io_wr = 1'b0;
  logic [2:0] io_off = '0;
  logic [7:0] io_wdata = '0, io_rdata;
  logic       mem_valid = 1'b0;
  logic [19:0] mem_addr = '0;
  logic card_en, eprom_en, ram_sel, prom_sel, prom_odd;
  logic ctl_data_sel, ctl_byte_hi, ctl_stat_sel, ctl_cmd_sel;
  logic [3:0] prom_idx;
  int total = 0, bad = 0;
  logic [5:0] m_base = '0;
  logic       m_en = 1'b0;

  always #2.5 clk = ~clk;

  optsel_window_top i_optsel_window_top (
    .clk_i(clk), .rst_ni(rst_n), .io_sel_i(io_sel), .io_wr_i(io_wr),
    .io_off_i(io_off), .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .mem_valid_i(mem_valid), .mem_addr_i(mem_addr),
    .card_en_o(card_en), .eprom_en_o(eprom_en), .ram_sel_o(ram_sel),
    .prom_sel_o(prom_sel), .prom_idx_o(prom_idx), .prom_odd_o(prom_odd),
    .ctl_data_sel_o(ctl_data_sel), .ctl_byte_hi_o(ctl_byte_hi),
    .ctl_stat_sel_o(ctl_stat_sel), .ctl_cmd_sel_o(ctl_cmd_sel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [2:0] off, input logic [7:0] d);
    @(negedge clk);
    io_sel = 1'b1; io_wr = 1'b1; io_off = off; io_wdata = d;
    @(posedge clk); #1;
    io_sel = 1'b0; io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [2:0] off, output logic [7:0] d);
    @(negedge clk);
    io_sel = 1'b1; io_wr = 1'b0; io_off = off;
    #1 d = io_rdata;
    io_sel = 1'b0;
  endtask

  // packs {ram,prom,idx[3:0],odd,data,hi,stat,cmd}
  function automatic logic [10:0] exp_dec(input logic v, input logic en,
                                          input logic [5:0] b, input logic [19:0] a);
    logic [13:0] o;
    logic [10:0] r;
    o = a[13:0];
    r = '0;
    if (v && en && b >= 6'h28 && a[19:14] == b) begin
      if (o <= 14'h3FBF) r[10] = 1'b1;
      else if (o <= 14'h3FDF) begin r[9] = 1'b1; r[8:5] = o[4:1]; r[4] = o[0]; end
      else if (o == 14'h3FF0 || o == 14'h3FF1) begin r[3] = 1'b1; r[2] = o[0]; end
      else if (o == 14'h3FF2) r[1] = 1'b1;
      else if (o == 14'h3FF3) r[0] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [10:0] got();
    return {ram_sel, prom_sel, prom_idx, prom_odd, ctl_data_sel, ctl_byte_hi, ctl_stat_sel, ctl_cmd_sel};
  endfunction

  task automatic mem_check(input string req, input logic v, input logic [19:0] a);
    @(negedge clk);
    mem_valid = v; mem_addr = a;
    #1 check(req, 32'(got()), 32'(exp_dec(v, m_en, m_base, a)));
    mem_valid = 1'b0;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    // R4 reset state
    io_read(3'd2, d); check("R4 ctrl", 32'(d), 32'h00);
    io_read(3'd3, d); check("R4 base", 32'(d), 32'h00);
    io_read(3'd4, d); check("R4 irq", 32'(d), 32'h00);
    mem_check("R4 no sel", 1'b1, 20'h00010);
    rst_n = 1'b1;
    io_read(3'd2, d); check("R4 ctrl after release", 32'(d), 32'h00);
    check("R2 eprom on after reset", 32'(eprom_en), 32'd1);
    // R1
    io_read(3'd0, d); check("R1 id lo", 32'(d), 32'hFD);
    io_read(3'd1, d); check("R1 id hi", 32'(d), 32'h6A);
    io_write(3'd0, 8'h12); io_write(3'd1, 8'h34);
    io_read(3'd0, d); check("R1 id lo after write", 32'(d), 32'hFD);
    io_read(3'd1, d); check("R1 id hi after write", 32'(d), 32'h6A);
    // R3
    io_write(3'd3, 8'hF3); m_base = 6'h33;
    io_read(3'd3, d); check("R3 base readback", 32'(d), 32'h33);
    // R5 with base set but card off
    mem_check("R5 card off", 1'b1, {6'h33, 14'h0100});
    // R2
    io_write(3'd2, 8'hFE);
    io_read(3'd2, d); check("R2 ctrl readback", 32'(d), 32'h02);
    check("R2 eprom disabled", 32'(eprom_en), 32'd0);
    check("R2 card still off", 32'(card_en), 32'd0);
    io_write(3'd2, 8'h01); m_en = 1'b1;
    check("R2 card on", 32'(card_en), 32'd1);
    check("R2 eprom on", 32'(eprom_en), 32'd1);
    // R7..R10 boundaries
    mem_check("R7 ram first", 1'b1, {6'h33, 14'h0000});
    mem_check("R7 ram last", 1'b1, {6'h33, 14'h3FBF});
    mem_check("R8 prom first", 1'b1, {6'h33, 14'h3FC0});
    mem_check("R8 prom odd", 1'b1, {6'h33, 14'h3FC5});
    mem_check("R8 prom last", 1'b1, {6'h33, 14'h3FDF});
    mem_check("R9 gap first", 1'b1, {6'h33, 14'h3FE0});
    mem_check("R9 gap last", 1'b1, {6'h33, 14'h3FEF});
    mem_check("R10 data lo", 1'b1, {6'h33, 14'h3FF0});
    mem_check("R10 data hi", 1'b1, {6'h33, 14'h3FF1});
    mem_check("R10 stat", 1'b1, {6'h33, 14'h3FF2});
    mem_check("R10 cmd", 1'b1, {6'h33, 14'h3FF3});
    mem_check("R9 top unmapped", 1'b1, {6'h33, 14'h3FF4});
    mem_check("R9 top last", 1'b1, {6'h33, 14'h3FFF});
    mem_check("R12 outside window", 1'b1, {6'h32, 14'h0000});
    mem_check("R12 valid low", 1'b0, {6'h33, 14'h0000});
    // R6 base edge
    io_write(3'd3, 8'h27); m_base = 6'h27;
    mem_check("R6 base 0x27", 1'b1, {6'h27, 14'h0000});
    io_write(3'd3, 8'h28); m_base = 6'h28;
    mem_check("R6 base 0x28", 1'b1, {6'h28, 14'h0000});
    io_write(3'd3, 8'h3F); m_base = 6'h3F;
    mem_check("R7 base 0x3F", 1'b1, {6'h3F, 14'h1234});
    // R11
    io_write(3'd4, 8'hA5);
    io_read(3'd4, d); check("R11 irq byte", 32'(d), 32'hA5);
    for (int k = 5; k < 8; k++) begin
      io_write(3'(k), 8'h00);
      io_read(3'(k), d); check("R11 unused reads FF", 32'(d), 32'hFF);
    end
    io_read(3'd3, d); check("R11 base unchanged", 32'(d), 32'h3F);
    io_read(3'd2, d); check("R11 ctrl unchanged", 32'(d), 32'h01);
    // random sweep: R5 R6 R7 R8 R10 R12
    for (int i = 0; i < 300; i++) begin
      if (i % 10 == 0) begin
        logic [7:0] cb, bb;
        cb = 8'($urandom()); bb = 8'($urandom());
        io_write(3'd2, cb); m_en = cb[0];
        io_write(3'd3, bb); m_base = bb[5:0];
      end
      begin
        logic [19:0] a;
        a = 20'($urandom());
        if ($urandom() % 2 == 0) a[19:14] = m_base;
        if ($urandom() % 3 == 0) a[13:6] = 8'hFF;
        mem_check("R12 random decode", ($urandom() % 8) != 0, a);
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule